// File: doc/BRIEF.md
# Video Frame Timer with Vertical-Blank Status

This block keeps the raster position of a video frame. A dot counter advances on every clock and a scanline counter advances each time the dot counter wraps. By default a line is 341 dots and a frame is 262 lines. When the raster reaches dot 1 of line 241, a vertical-blank flag is set. The flag clears again at dot 1 of line 261, which is the last line before the counters wrap to the top of the frame.

A processor watches the flag through a small read-only bus port. The port has a chip select, a read strobe and a 3-bit register index. Reading the status register returns the flag in bit 7 and zero in every other bit. The read also clears the flag at the end of the read cycle.

The flag drives a level interrupt request, gated by an enable input. The block also produces a clock enable that pulses once every third dot clock, for a processor that runs at one third of the dot rate.

Top module: `vid_frame_timer`

## Requirements
- R1: After reset the dot position is 0. It rises by one per clock up to DOTS_PER_LINE-1 (default 340) and then returns to 0.
- R2: The line position rises by one each time the dot position wraps and returns to 0 after line LINES_PER_FRAME-1 (default 261), so a frame lasts DOTS_PER_LINE*LINES_PER_FRAME clocks.
- R3: The flag becomes 1 at the clock edge that moves the raster onto dot VBL_SET_DOT of line VBL_SET_LINE (default dot 1, line 241). It is 1 while that dot is shown.
- R4: The flag becomes 0 at the clock edge that moves the raster onto dot VBL_CLR_DOT of line VBL_CLR_LINE (default dot 1, line 261).
- R5: A status read (cs_i=1, rd_i=1, addr_i=2) drives rdata_o with the flag in bit 7 and 0 in bits 6..0, all in the same cycle. Any other bus state drives rdata_o to 8'h00.
- R6: A status read clears the flag at the clock edge that ends the read cycle. If that same edge is the set edge of R3, the flag is set instead.
- R7: A bus cycle with cs_i=0, with rd_i=0, or with an index other than 2 leaves the flag unchanged.
- R8: nmi_o is high exactly while the flag is 1 and nmi_en_i is 1.
- R9: cpu_ce_o is high for one clock in every CE_DIV clocks (default 3), first in the CE_DIV-th clock after reset is released.
- R10: While reset is asserted, dot and line are 0, the flag is 0, nmi_o is 0 and cpu_ce_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Dot clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cs_i | input | 1 | Register port select |
| rd_i | input | 1 | Read strobe |
| addr_i | input | 3 | Register index; 2 selects status |
| nmi_en_i | input | 1 | Interrupt request enable |
| rdata_o | output | 8 | Read data; bit 7 is the vertical-blank flag |
| nmi_o | output | 1 | Level interrupt request |
| cpu_ce_o | output | 1 | One-in-CE_DIV clock enable |
| dot_o | output | $clog2(DOTS_PER_LINE) | Current dot within the line |
| line_o | output | $clog2(LINES_PER_FRAME) | Current line within the frame |

## Verification
A reduced raster of 11 dots by 8 lines is swept clock by clock over five frames, and a different bus pattern is used in each frame.

- A frame with no reads shows that the flag sets and clears only at the raster positions.
- A frame that cycles through every register index on every clock separates status reads from other indices.
- A read placed on the cycle just before the set edge tests the set-over-clear priority.
- Reads with chip select or strobe held low must leave the flag alone.
- A toggling enable tests the interrupt gating.

A second instance at full size is checked at the set edge, the clear edge and the frame wrap.

// File: rtl/vft_pkg.sv
package vft_pkg;
  localparam logic [2:0] STATUS_IDX = 3'd2;
  localparam int unsigned VBL_BIT = 7;

  typedef struct packed {
    logic       cs;
    logic       rd;
    logic [2:0] idx;
  } bus_req_t;
endpackage

// File: rtl/vft_dot_line.sv
module vft_dot_line #(
  parameter int unsigned DOTS  = 341,
  parameter int unsigned LINES = 262,
  localparam int unsigned DW = $clog2(DOTS),
  localparam int unsigned LW = $clog2(LINES)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  output logic [DW-1:0] dot_o,
  output logic [LW-1:0] line_o,
  output logic [DW-1:0] nxt_dot_o,
  output logic [LW-1:0] nxt_line_o
);
  logic [DW-1:0] dot_q;
  logic [LW-1:0] line_q;
  logic          last_dot, last_line;

  assign last_dot  = (dot_q == DW'(DOTS - 1));
  assign last_line = (line_q == LW'(LINES - 1));

  always_comb begin
    nxt_dot_o  = last_dot ? '0 : dot_q + DW'(1);
    nxt_line_o = line_q;
    if (last_dot) nxt_line_o = last_line ? '0 : line_q + LW'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dot_q  <= '0;
      line_q <= '0;
    end else begin
      dot_q  <= nxt_dot_o;
      line_q <= nxt_line_o;
    end
  end

  assign dot_o  = dot_q;
  assign line_o = line_q;

  a_r1_dot_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dot_q <= DW'(DOTS - 1));
  a_r1_dot_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !last_dot |=> dot_q == $past(dot_q) + DW'(1));
  a_r2_line_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !last_dot |=> $stable(line_q));
  a_r2_frame_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (last_dot && last_line) |=> (dot_q == '0 && line_q == '0));
endmodule

// File: rtl/vft_vbl_status.sv
module vft_vbl_status
  import vft_pkg::*;
#(
  parameter int unsigned DW       = 9,
  parameter int unsigned LW       = 9,
  parameter int unsigned SET_DOT  = 1,
  parameter int unsigned SET_LINE = 241,
  parameter int unsigned CLR_DOT  = 1,
  parameter int unsigned CLR_LINE = 261
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [DW-1:0] nxt_dot_i,
  input  logic [LW-1:0] nxt_line_i,
  input  bus_req_t      req_i,
  input  logic          nmi_en_i,
  output logic [7:0]    rdata_o,
  output logic          nmi_o
);
  logic flag_q, set_evt, clr_evt, rd_hit;

  // events fire on the edge that enters the target dot
  assign set_evt = (nxt_line_i == LW'(SET_LINE)) && (nxt_dot_i == DW'(SET_DOT));
  assign clr_evt = (nxt_line_i == LW'(CLR_LINE)) && (nxt_dot_i == DW'(CLR_DOT));
  assign rd_hit  = req_i.cs && req_i.rd && (req_i.idx == STATUS_IDX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      flag_q <= 1'b0;
    else if (set_evt) flag_q <= 1'b1;
    else if (clr_evt) flag_q <= 1'b0;
    else if (rd_hit)  flag_q <= 1'b0;
  end

  always_comb begin
    rdata_o = '0;
    if (rd_hit) rdata_o[VBL_BIT] = flag_q;
  end

  assign nmi_o = flag_q & nmi_en_i;

  a_r3_flag_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_evt |=> flag_q);
  a_r4_flag_clr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_evt && !set_evt) |=> !flag_q);
  a_r6_read_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_hit && !set_evt) |=> !flag_q);
  a_r6_read_drops_nmi: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_hit && !set_evt) |=> !nmi_o);
  a_r7_flag_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rd_hit && !set_evt && !clr_evt) |=> $stable(flag_q));
endmodule

// File: rtl/vft_ce_div.sv
module vft_ce_div #(
  parameter int unsigned DIV = 3,
  localparam int unsigned CW = (DIV > 2) ? $clog2(DIV) : 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic ce_o
);
  logic [CW-1:0] cnt_q;
  logic          wrap;

  assign wrap = (cnt_q == CW'(DIV - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cnt_q <= '0;
    else if (wrap) cnt_q <= '0;
    else           cnt_q <= cnt_q + CW'(1);
  end

  assign ce_o = wrap;

  a_r9_ce_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ce_o |=> !ce_o);
  a_r9_cnt_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(DIV - 1));
endmodule

// File: rtl/vid_frame_timer.sv
module vid_frame_timer
  import vft_pkg::*;
#(
  parameter int unsigned DOTS_PER_LINE   = 341,
  parameter int unsigned LINES_PER_FRAME = 262,
  parameter int unsigned VBL_SET_LINE    = 241,
  parameter int unsigned VBL_SET_DOT     = 1,
  parameter int unsigned VBL_CLR_LINE    = 261,
  parameter int unsigned VBL_CLR_DOT     = 1,
  parameter int unsigned CE_DIV          = 3,
  localparam int unsigned DW = $clog2(DOTS_PER_LINE),
  localparam int unsigned LW = $clog2(LINES_PER_FRAME)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cs_i,
  input  logic          rd_i,
  input  logic [2:0]    addr_i,
  input  logic          nmi_en_i,
  output logic [7:0]    rdata_o,
  output logic          nmi_o,
  output logic          cpu_ce_o,
  output logic [DW-1:0] dot_o,
  output logic [LW-1:0] line_o
);
  logic [DW-1:0] nxt_dot;
  logic [LW-1:0] nxt_line;
  bus_req_t      req;

  assign req = '{cs: cs_i, rd: rd_i, idx: addr_i};

  vft_dot_line #(
    .DOTS (DOTS_PER_LINE),
    .LINES(LINES_PER_FRAME)
  ) u_raster (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .dot_o     (dot_o),
    .line_o    (line_o),
    .nxt_dot_o (nxt_dot),
    .nxt_line_o(nxt_line)
  );

  vft_vbl_status #(
    .DW      (DW),
    .LW      (LW),
    .SET_DOT (VBL_SET_DOT),
    .SET_LINE(VBL_SET_LINE),
    .CLR_DOT (VBL_CLR_DOT),
    .CLR_LINE(VBL_CLR_LINE)
  ) u_status (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .nxt_dot_i (nxt_dot),
    .nxt_line_i(nxt_line),
    .req_i     (req),
    .nmi_en_i  (nmi_en_i),
    .rdata_o   (rdata_o),
    .nmi_o     (nmi_o)
  );

  vft_ce_div #(
    .DIV(CE_DIV)
  ) u_ce (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .ce_o  (cpu_ce_o)
  );

  a_r10_reset_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dot_o == '0 && line_o == '0 && $past(!rst_ni)) |-> !nmi_o);
endmodule

// File: tb/sim_vid_frame_timer.sv
`timescale 1ns/1ps
module sim_vid_frame_timer;
  localparam int D = 11, L = 8, SL = 5, SD = 1, CL = 7, CD = 1;
  localparam int F = D * L, SETP = SL * D + SD, CLRP = CL * D + CD;
  localparam int BF = 341 * 262, BSET = 241 * 341 + 1, BCLR = 261 * 341 + 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cs = 1'b0, rd = 1'b0, en = 1'b0;
  logic [2:0] idx = 3'd0;
  logic [7:0] rdata, rdata1;
  logic nmi, ce, nmi1, ce1;
  logic [3:0] dot;
  logic [2:0] line;
  logic [8:0] dot1, line1;

  int n_chk = 0, n_fail = 0, cyc = 0, pn = 0;
  logic mflag = 1'b0, last_hit = 1'b0;
  bit done = 0;

  always #2.5 clk = ~clk;

  vid_frame_timer #(
    .DOTS_PER_LINE(D), .LINES_PER_FRAME(L), .VBL_SET_LINE(SL), .VBL_SET_DOT(SD),
    .VBL_CLR_LINE(CL), .VBL_CLR_DOT(CD), .CE_DIV(3)
  ) u0 (
    .clk_i(clk), .rst_ni(rst_n), .cs_i(cs), .rd_i(rd), .addr_i(idx), .nmi_en_i(en),
    .rdata_o(rdata), .nmi_o(nmi), .cpu_ce_o(ce), .dot_o(dot), .line_o(line)
  );

  vid_frame_timer u1 (
    .clk_i(clk), .rst_ni(rst_n), .cs_i(1'b0), .rd_i(1'b0), .addr_i(3'd0), .nmi_en_i(1'b1),
    .rdata_o(rdata1), .nmi_o(nmi1), .cpu_ce_o(ce1), .dot_o(dot1), .line_o(line1)
  );

  // reference flag for u0, from the raster arithmetic of R3/R4/R6
  always @(posedge clk) begin
    if (rst_n) begin
      pn = (cyc + 1) % F;
      if (pn == SETP)                      mflag <= 1'b1;
      else if (pn == CLRP)                 mflag <= 1'b0;
      else if (cs && rd && idx == 3'd2)    mflag <= 1'b0;
      last_hit <= cs && rd && idx == 3'd2;
      cyc <= cyc + 1;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s act=%0d exp=%0d cyc=%0d", tag, act, exp, cyc);
    end
  endtask

  task automatic drive(input int k);
    int f, p;
    f = k / F; p = k % F;
    cs = 1'b0; rd = 1'b0; idx = 3'd0; en = 1'b1;
    case (f)
      1: begin cs = 1'b1; rd = 1'b1; idx = 3'(k % 8); end
      2: if (p == SETP - 1 || p == SETP + 3 || p == SETP + 4) begin
           cs = 1'b1; rd = 1'b1; idx = 3'd2;
         end
      3: begin
           idx = (p % 5 == 0) ? 3'd3 : 3'd2;
           cs = (p % 2 == 0) || (p % 5 == 0);
           rd = (p % 2 == 1) || (p % 5 == 0);
         end
      4: en = (k % 2 == 1);
      default: ;
    endcase
  endtask

  initial begin
    #20;
    @(negedge clk);
    // R10 reset state
    cs = 1'b1; rd = 1'b1; idx = 3'd2; en = 1'b1;
    #1;
    chk("R10 dot", dot, 0);
    chk("R10 line", line, 0);
    chk("R10 nmi", nmi, 0);
    chk("R10 ce", ce, 0);
    chk("R10 rdata", rdata, 0);
    chk("R10 nmi_full", nmi1, 0);
    @(negedge clk); @(negedge clk);
    chk("R10 dot_held", dot, 0);
    rst_n = 1'b1;
    for (int k = 0; k <= BF + 1; k++) begin
      if (k < 5 * F) drive(k);
      else begin cs = 1'b0; rd = 1'b0; en = 1'b0; end
      #1;
      if (k < 5 * F) begin
        int p;
        string t;
        p = k % F;
        chk("R1 dot", dot, p % D);
        chk("R2 line", line, p / D);
        chk("R9 ce", ce, (k % 3 == 2) ? 1 : 0);
        chk("R5 rdata", rdata, (cs && rd && idx == 3'd2) ? (mflag ? 128 : 0) : 0);
        if (k / F == 4) t = "R8 nmi_gate";
        else if (p == SETP) t = "R3 set";
        else if (p == CLRP) t = "R4 clear";
        else if (last_hit) t = "R6 read_clear";
        else t = "R7 hold";
        chk(t, nmi, (mflag && en) ? 1 : 0);
      end
      if (k == BSET - 1) chk("R3 full_before", nmi1, 0);
      if (k == BSET)     chk("R3 full_set", nmi1, 1);
      if (k == BCLR - 1) chk("R4 full_before", nmi1, 1);
      if (k == BCLR)     chk("R4 full_clear", nmi1, 0);
      if (k == BF - 1) begin
        chk("R2 full_last_dot", dot1, 340);
        chk("R2 full_last_line", line1, 261);
      end
      if (k == BF) begin
        chk("R1 full_wrap_dot", dot1, 0);
        chk("R2 full_wrap_line", line1, 0);
      end
      @(negedge clk);
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    #1500000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog act=%0d exp=%0d", cyc, BF + 2);
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end
endmodule